// File: doc/BRIEF.md
# Compressed Branch and Link Unit

This block resolves the branch-class instructions of a 16-bit compressed instruction set: the conditional branch, the unconditional branch and the long branch-with-link that is split over two halfwords. Each cycle in which `instValid` is high, the block takes the current halfword, the halfword that follows it, the current PC, the four condition flags and the present link register value. One clock later it reports its result on registered outputs:

- a taken strobe with the new PC;
- a link write strobe with the value to write;
- a pipeline flush request;
- an undefined-instruction flag.

The block evaluates the condition codes itself. It fuses the two halves of a long branch when they arrive together, and it also accepts either half on its own, passing the partial target through the link register. The register file, instruction fetch and exception entry are outside the block. A software interrupt encoding is left for another unit, and the block produces no output for it.

Top module: `brlnk_unit`

## Requirements
- R1: After reset, every output strobe (`takenStb`, `linkWrStb`, `flushReq`, `undefFlag`) is low. Every strobe is also low in the cycle after a cycle in which `instValid` was low, whatever the halfword inputs were.
- R2: The top code is `curHalf[15:11]`. For top codes 26 and 27, the condition field `curHalf[11:8]` decodes as follows:
  - 4'b1110 raises `undefFlag` and nothing else;
  - 4'b1111 (software interrupt) raises no output at all;
  - every other value is a conditional branch.
- R3: The condition field is decoded as follows:
  - 0 takes on Z, and 1 on not Z;
  - 2 takes on C, and 3 on not C;
  - 4 takes on N, and 5 on not N;
  - 6 takes on V, and 7 on not V;
  - 8 takes on C and not Z;
  - 9 takes on not C or Z;
  - 10 takes on N equal to V, and 11 on N not equal to V;
  - 12 takes on not Z and N equal to V;
  - 13 takes on Z or N not equal to V.
- R4: A taken conditional branch sets `newPc` = `pc` + 4 + ({`curHalf[7:0]`, 1'b0} sign-extended from `curHalf[7]`).
- R5: A conditional branch whose condition fails raises no strobe: no taken, no flush and no link write.
- R6: Top code 28 always branches to `pc` + 4 + ({`curHalf[10:0]`, 1'b0} sign-extended from `curHalf[10]`).
- R7: Top code 29 raises `undefFlag` alone. Top codes 0 to 25 raise no output.
- R8: When top code 30 is not followed by a `nextHalf` with top code 31, the block writes the link with `pc` + (`curHalf[10:0]` shifted left by 12, sign-extended from `curHalf[10]`). It raises no taken and no flush.
- R9: When top code 30 is followed by a `nextHalf` with top code 31, the two halves complete in one operation:
  - `newPc` = the R8 link value + (`nextHalf[10:0]` shifted left by 1, zero-extended);
  - the link is written with (`pc` + 4) with bit 0 set;
  - taken and flush are raised.
- R10: Top code 31 on its own sets `newPc` = `linkIn` + (`curHalf[10:0]` shifted left by 1). It writes the link with (`pc` + 2) with bit 0 set, and raises taken and flush.
- R11: `flushReq` is high exactly in the cycles in which `takenStb` is high.
- R12: Outputs appear in the clock cycle after the instruction is sampled. Each instruction produces at most one kind of action, and strobes last only for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | The halfword inputs hold an instruction this cycle |
| curHalf | input | 16 | Halfword being resolved |
| nextHalf | input | 16 | Halfword following it in program order |
| pc | input | ADDR_W | Address of `curHalf` |
| linkIn | input | ADDR_W | Present link register value |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| takenStb | output | 1 | A branch is taken; `newPc` is valid |
| newPc | output | ADDR_W | Branch target |
| linkWrStb | output | 1 | Write `linkVal` to the link register |
| linkVal | output | ADDR_W | Link register write value |
| flushReq | output | 1 | Pipeline flush request |
| undefFlag | output | 1 | Undefined instruction |

## Verification
The bench sweeps all fourteen branch conditions against all sixteen flag combinations. A decoder that swapped a flag or mixed up the signed and unsigned comparisons would then take a branch it should skip, or the reverse. It drives negative offsets for all three offset widths; a design that zero-extended where it should sign-extend would jump forward instead of back. It covers the first long-branch half both with and without a matching second half, and the second half alone. A unit that never fused the halves, fused them by mistake, or took the second half's PC from the wrong halfword would produce a wrong target or a link value off by two. The reserved condition 1110, the interrupt code 1111, top code 29 and an idle cycle carrying a branch pattern check that no undefined or ignored encoding leaks a strobe.

// File: rtl/brlnk_pkg.sv
package brlnk_pkg;

  localparam int HALF_W = 16;
  localparam int TOP_W  = 5;

  localparam logic [TOP_W-1:0] TOP_COND_A  = 5'd26;
  localparam logic [TOP_W-1:0] TOP_COND_B  = 5'd27;
  localparam logic [TOP_W-1:0] TOP_UNCOND  = 5'd28;
  localparam logic [TOP_W-1:0] TOP_UNDEF   = 5'd29;
  localparam logic [TOP_W-1:0] TOP_LONG_HI = 5'd30;
  localparam logic [TOP_W-1:0] TOP_LONG_LO = 5'd31;

  localparam logic [3:0] COND_RESERVED = 4'b1110;
  localparam logic [3:0] COND_SWINT    = 4'b1111;

  // One strobe per action kind; at most one is set for any instruction.
  typedef struct packed {
    logic condTaken;
    logic uncond;
    logic longFirst;
    logic longSecond;
    logic longFused;
    logic undef;
  } brCtrl_t;

endpackage

// File: rtl/brlnk_ctrl.sv
module brlnk_ctrl
  import brlnk_pkg::*;
(
  input  logic             instValid,
  input  logic [TOP_W-1:0] curTop,
  input  logic [3:0]       condField,
  input  logic [TOP_W-1:0] nextTop,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagC,
  input  logic             flagV,
  output brCtrl_t          ctrl
);

  function automatic logic condHolds(input logic [3:0] cc, input logic n,
                                     input logic z, input logic c, input logic v);
    logic r;
    unique case (cc)
      4'd0:    r = z;
      4'd1:    r = !z;
      4'd2:    r = c;
      4'd3:    r = !c;
      4'd4:    r = n;
      4'd5:    r = !n;
      4'd6:    r = v;
      4'd7:    r = !v;
      4'd8:    r = c && !z;
      4'd9:    r = !c || z;
      4'd10:   r = (n == v);
      4'd11:   r = (n != v);
      4'd12:   r = !z && (n == v);
      4'd13:   r = z || (n != v);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  logic condPass;
  assign condPass = condHolds(condField, flagN, flagZ, flagC, flagV);

  always_comb begin
    ctrl = '0;
    if (instValid) begin
      unique case (curTop)
        TOP_COND_A, TOP_COND_B: begin
          if (condField == COND_RESERVED)   ctrl.undef = 1'b1;
          else if (condField != COND_SWINT) ctrl.condTaken = condPass;
        end
        TOP_UNCOND: ctrl.uncond = 1'b1;
        TOP_UNDEF:  ctrl.undef  = 1'b1;
        TOP_LONG_HI: begin
          if (nextTop == TOP_LONG_LO) ctrl.longFused = 1'b1;
          else                        ctrl.longFirst = 1'b1;
        end
        TOP_LONG_LO: ctrl.longSecond = 1'b1;
        default: ctrl = '0;
      endcase
    end
  end

endmodule

// File: rtl/brlnk_dpath.sv
module brlnk_dpath
  import brlnk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  brCtrl_t           ctrl,
  input  logic [10:0]       curField,
  input  logic [10:0]       nextField,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] linkIn,
  output logic              takenStb,
  output logic [ADDR_W-1:0] newPc,
  output logic              linkWrStb,
  output logic [ADDR_W-1:0] linkVal,
  output logic              flushReq,
  output logic              undefFlag
);

  localparam int PAD8  = ADDR_W - 9;
  localparam int PAD11 = ADDR_W - 12;
  localparam int PADHI = ADDR_W - 23;

  logic [ADDR_W-1:0] condOff, uncondOff, hiOff, loOffCur, loOffNext;
  logic [ADDR_W-1:0] pcPlus2, pcPlus4, firstLink;
  logic [ADDR_W-1:0] nextPcVal, nextLinkVal;
  logic              nextTaken, nextLinkWr;

  // Offset forms: short conditional, unconditional, long high, long low.
  assign condOff   = {{PAD8{curField[7]}}, curField[7:0], 1'b0};
  assign uncondOff = {{PAD11{curField[10]}}, curField, 1'b0};
  assign hiOff     = {{PADHI{curField[10]}}, curField, 12'b0};
  assign loOffCur  = {{PAD11{1'b0}}, curField, 1'b0};
  assign loOffNext = {{PAD11{1'b0}}, nextField, 1'b0};

  assign pcPlus2   = pc + ADDR_W'(2);
  assign pcPlus4   = pc + ADDR_W'(4);
  assign firstLink = pc + hiOff;

  always_comb begin
    nextTaken   = ctrl.condTaken | ctrl.uncond | ctrl.longSecond | ctrl.longFused;
    nextLinkWr  = ctrl.longFirst | ctrl.longSecond | ctrl.longFused;
    nextPcVal   = '0;
    nextLinkVal = '0;
    if (ctrl.condTaken)  nextPcVal = pcPlus4 + condOff;
    if (ctrl.uncond)     nextPcVal = pcPlus4 + uncondOff;
    if (ctrl.longFused)  nextPcVal = firstLink + loOffNext;
    if (ctrl.longSecond) nextPcVal = linkIn + loOffCur;
    if (ctrl.longFirst)  nextLinkVal = firstLink;
    if (ctrl.longFused)  nextLinkVal = {pcPlus4[ADDR_W-1:1], 1'b1};
    if (ctrl.longSecond) nextLinkVal = {pcPlus2[ADDR_W-1:1], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      takenStb  <= 1'b0;
      linkWrStb <= 1'b0;
      flushReq  <= 1'b0;
      undefFlag <= 1'b0;
      newPc     <= '0;
      linkVal   <= '0;
    end else begin
      takenStb  <= nextTaken;
      linkWrStb <= nextLinkWr;
      flushReq  <= ctrl.condTaken | ctrl.uncond | ctrl.longSecond | ctrl.longFused;
      undefFlag <= ctrl.undef;
      newPc     <= nextPcVal;
      linkVal   <= nextLinkVal;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl)); // R12

  AST_FIRST_HALF_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    ctrl.longFirst |=> linkWrStb && !takenStb && !flushReq); // R8

endmodule

// File: rtl/brlnk_unit.sv
module brlnk_unit
  import brlnk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [15:0]       curHalf,
  input  logic [15:0]       nextHalf,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] linkIn,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  output logic              takenStb,
  output logic [ADDR_W-1:0] newPc,
  output logic              linkWrStb,
  output logic [ADDR_W-1:0] linkVal,
  output logic              flushReq,
  output logic              undefFlag
);

  brCtrl_t ctrl;

  brlnk_ctrl u_ctrl (
    .instValid (instValid),
    .curTop    (curHalf[15:11]),
    .condField (curHalf[11:8]),
    .nextTop   (nextHalf[15:11]),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .flagC     (flagC),
    .flagV     (flagV),
    .ctrl      (ctrl)
  );

  brlnk_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .curField  (curHalf[10:0]),
    .nextField (nextHalf[10:0]),
    .pc        (pc),
    .linkIn    (linkIn),
    .takenStb  (takenStb),
    .newPc     (newPc),
    .linkWrStb (linkWrStb),
    .linkVal   (linkVal),
    .flushReq  (flushReq),
    .undefFlag (undefFlag)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !takenStb && !linkWrStb && !flushReq && !undefFlag); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> !takenStb && !linkWrStb && !flushReq && !undefFlag); // R1

  AST_FLUSH_MATCHES_TAKEN: assert property (@(posedge clk) disable iff (rst)
    flushReq == takenStb); // R11

  AST_UNDEF_ALONE: assert property (@(posedge clk) disable iff (rst)
    undefFlag |-> !takenStb && !linkWrStb); // R7

  AST_RETURN_LINK_ODD: assert property (@(posedge clk) disable iff (rst)
    takenStb && linkWrStb |-> linkVal[0]); // R10

endmodule

// File: tb/brlnk_unit_tb_top.sv
module brlnk_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct {
    logic        taken;
    logic [31:0] npc;
    logic        lwr;
    logic [31:0] lval;
    logic        undef;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [15:0] curHalf = '0, nextHalf = '0;
  logic [AW-1:0] pc = '0, linkIn = '0;
  logic flagN = 0, flagZ = 0, flagC = 0, flagV = 0;
  logic takenStb, linkWrStb, flushReq, undefFlag;
  logic [AW-1:0] newPc, linkVal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  brlnk_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .instValid(instValid), .curHalf(curHalf),
    .nextHalf(nextHalf), .pc(pc), .linkIn(linkIn), .flagN(flagN),
    .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .takenStb(takenStb),
    .newPc(newPc), .linkWrStb(linkWrStb), .linkVal(linkVal),
    .flushReq(flushReq), .undefFlag(undefFlag)
  );

  // Condition table written from the requirement (R3).
  function automatic logic ccPass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c & ~z;     9: return ~c | z;
      10: return n == v;    11: return n != v;
      12: return ~z & (n == v);
      13: return z | (n != v);
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model(input logic v, input logic [15:0] h,
      input logic [15:0] nx, input logic [31:0] p, input logic [31:0] l,
      input logic [3:0] f, input string tag);
    exp_t e;
    int top;
    logic [31:0] hi;
    e.taken = 0; e.npc = 0; e.lwr = 0; e.lval = 0; e.undef = 0; e.tag = tag;
    top = int'(h[15:11]);
    if (v) begin
      if (top == 26 || top == 27) begin
        if (h[11:8] == 4'hE) e.undef = 1;
        else if (h[11:8] != 4'hF && ccPass(h[11:8], f)) begin
          e.taken = 1;
          e.npc = p + 32'd4 + {{23{h[7]}}, h[7:0], 1'b0};
        end
      end else if (top == 28) begin
        e.taken = 1;
        e.npc = p + 32'd4 + {{20{h[10]}}, h[10:0], 1'b0};
      end else if (top == 29) begin
        e.undef = 1;
      end else if (top == 30) begin
        hi = p + {{9{h[10]}}, h[10:0], 12'b0};
        e.lwr = 1;
        if (nx[15:11] == 5'd31) begin
          e.taken = 1;
          e.npc = hi + {20'b0, nx[10:0], 1'b0};
          e.lval = (p + 32'd4) | 32'd1;
        end else e.lval = hi;
      end else if (top == 31) begin
        e.taken = 1; e.lwr = 1;
        e.npc = l + {20'b0, h[10:0], 1'b0};
        e.lval = (p + 32'd2) | 32'd1;
      end
    end
    return e;
  endfunction

  task automatic drive(input logic v, input logic [15:0] h, input logic [15:0] nx,
                       input logic [31:0] p, input logic [31:0] l,
                       input logic [3:0] f, input string tag);
    @(negedge clk);
    instValid = v; curHalf = h; nextHalf = nx; pc = p; linkIn = l;
    {flagN, flagZ, flagC, flagV} = f;
    q.push_back(model(v, h, nx, p, l, f, tag));
  endtask

  // Monitor: one result per driven cycle, seen just after the capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = (takenStb !== e.taken) || (flushReq !== e.taken) ||
              (linkWrStb !== e.lwr) || (undefFlag !== e.undef) ||
              (e.taken && newPc !== e.npc) || (e.lwr && linkVal !== e.lval);
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: got taken=%b flush=%b pc=%h lwr=%b link=%h undef=%b exp taken=%b pc=%h lwr=%b link=%h undef=%b",
                   e.tag, takenStb, flushReq, newPc, linkWrStb, linkVal, undefFlag,
                   e.taken, e.npc, e.lwr, e.lval, e.undef);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (takenStb !== 0 || linkWrStb !== 0 || flushReq !== 0 || undefFlag !== 0) begin
      errors++;
      $display("FAIL R1 reset: got %b%b%b%b exp 0000", takenStb, linkWrStb, flushReq, undefFlag);
    end
    rst = 0;

    // R3 R4 R5 R12: every condition against every flag combination
    for (int f = 0; f < 16; f++)
      for (int cc = 0; cc < 14; cc++)
        drive(1, {4'b1101, 4'(cc), 8'(8'h35 + f * 29 + cc * 7)}, 16'h0,
              32'h0000_4000 + 32'(f * 64), 32'h0, 4'(f), "R3/R4/R5 cond");

    // R4 negative and extreme offsets
    drive(1, 16'hD080, 16'h0, 32'h0000_1000, 0, 4'b0100, "R4 min offset");
    drive(1, 16'hD07F, 16'h0, 32'h0000_1000, 0, 4'b0100, "R4 max offset");
    // R2 reserved and interrupt fields
    drive(1, 16'hDE12, 16'h0, 32'h100, 0, 4'b1111, "R2 reserved cond");
    drive(1, 16'hDF18, 16'h0, 32'h100, 0, 4'b1111, "R2 swint");
    // R6 unconditional both directions
    drive(1, 16'hE155, 16'h0, 32'h0000_2000, 0, 4'b0000, "R6 forward");
    drive(1, 16'hE7FF, 16'h0, 32'h0000_2000, 0, 4'b0000, "R6 back");
    drive(1, 16'hE400, 16'h0, 32'h0000_2000, 0, 4'b1010, "R6 min");
    // R7 undefined and ignored codes
    drive(1, 16'hE812, 16'h0, 32'h300, 0, 4'b0, "R7 code29");
    drive(1, 16'h0000, 16'hF800, 32'h300, 0, 4'b0, "R7 code0");
    drive(1, 16'hCFFF, 16'h0, 32'h300, 0, 4'b0, "R7 code25");
    // R8 first half alone, positive and negative
    drive(1, 16'hF012, 16'h0000, 32'h0100_0000, 32'h55, 4'b0, "R8 first pos");
    drive(1, 16'hF400, 16'hE000, 32'h0100_0000, 32'h55, 4'b0, "R8 first neg");
    // R9 fused long branch
    drive(1, 16'hF001, 16'hF923, 32'h0000_8000, 32'h77, 4'b0, "R9 fused");
    drive(1, 16'hF7FF, 16'hFFFF, 32'h0000_8000, 32'h77, 4'b0, "R9 fused neg");
    // R10 second half alone
    drive(1, 16'hFFFF, 16'h0, 32'h0000_3002, 32'h0000_2000, 4'b0, "R10 second");
    drive(1, 16'hF800, 16'hF800, 32'h0000_3000, 32'hABCD_0000, 4'b0, "R10 second zero");
    // R1 idle cycles carrying branch patterns
    drive(0, 16'hE155, 16'h0, 32'h100, 0, 4'b0, "R1 idle uncond");
    drive(0, 16'hF001, 16'hF800, 32'h100, 0, 4'b0, "R1 idle long");
    // R11 R12 back-to-back branches then a quiet instruction
    drive(1, 16'hE002, 16'h0, 32'h400, 0, 4'b0, "R11 b2b 1");
    drive(1, 16'hD0FE, 16'h0, 32'h500, 0, 4'b0100, "R11 b2b 2");
    drive(1, 16'hD0FE, 16'h0, 32'h500, 0, 4'b0000, "R12 strobe drop");
    drive(0, 16'h0, 16'h0, 0, 0, 4'b0, "R1 final idle");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule